// File: doc/BRIEF.md
# Texture Coordinate Conditioner

This unit turns one axis of a sampler's fixed-point texture coordinate into an integer texel index within a tile. The coordinate first gets a scale step from a 4-bit shift code, which can shift right or left. The unit then limits it to the tile's low and high bounds, makes it relative to the low bound, and folds it into a power-of-two window. It can repeat the window as it is, or repeat it with every other copy reversed. The fraction bits of the limited coordinate are passed out unchanged so that a filter stage can use them.

A sampler uses two copies of this unit, one per axis. Each copy gets its own coordinate and its own set of tile fields. The unit is a two-stage pipeline: the scale step sits in the first stage, and limiting, folding and reversal sit in the second. A valid flag travels with the data.

Top module: `tex_coord_cond`

## Requirements
- R1: `out_valid` is high exactly two clock edges after `in_valid` was sampled high, and low otherwise. Back-to-back and gapped strobes are both supported.
- R2: `shift_code` 0 leaves the coordinate unscaled. Codes 1 to 10 shift it right arithmetically (toward minus infinity) by the code value. Codes 11, 12, 13, 14 and 15 shift it left by 5, 4, 3, 2 and 1 bits.
- R3: `coord_in` is signed two's complement with 5 fraction bits. `lo_bound` and `hi_bound` are unsigned with 2 fraction bits. Limiting compares at full fraction precision. `frac_out` carries the 5 fraction bits of the scaled, limited coordinate.
- R4: When `mask` is 0, the scaled coordinate is limited to [lo_bound, hi_bound] whatever the value of `clamp_en`.
- R5: When `mask` N is nonzero, limiting happens only if `clamp_en` is 1. The index keeps only its lowest N bits, so it repeats every 2^N texels.
- R6: A `mask` value above 10 behaves exactly like 10.
- R7: When `mirror_en` is 1 and N is nonzero, bit N of the tile-relative index is tested. If that bit is 1, the low N bits are inverted. For example, mask 2 maps 0..7 to 0,1,2,3,3,2,1,0. When N is 0, `mirror_en` has no effect.
- R8: Limiting is applied before folding and reversal. With lo 0, hi 11, mask 2, mirror and clamp on, the integer inputs 0..15 give 0,1,2,3,3,2,1,0,0,1,2,3,3,3,3,3.
- R9: A coordinate below the low bound is limited to the low bound. The index is the integer part of the limited coordinate minus the integer part of `lo_bound`, and `texel_out` carries its low 10 bits in two's complement.
- R10: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input coordinate and fields are valid |
| coord_in | input | 16 | Signed coordinate, 5 fraction bits |
| shift_code | input | 4 | Scale code |
| mask | input | 4 | Window width in bits, 0 selects pure limiting |
| mirror_en | input | 1 | Reverse alternate windows |
| clamp_en | input | 1 | Limit to bounds when mask is nonzero |
| lo_bound | input | 12 | Low tile bound, unsigned, 2 fraction bits |
| hi_bound | input | 12 | High tile bound, unsigned, 2 fraction bits |
| out_valid | output | 1 | Output index is valid |
| texel_out | output | 10 | Tile-relative texel index |
| frac_out | output | 5 | Fraction bits of the limited coordinate |

## Verification
Limiting at the high bound and window reversal can both act on the same coordinate in one cycle. The limited value then lands on a reversed or unreversed window, depending on the bit above the mask. A sweep across the high bound, with mirror and clamp both on, provokes this case. A large number of random field and coordinate combinations also provokes it. Each result is judged against an integer model in the bench that applies scaling, limiting, relative offset, folding and reversal in that order, and the comparison is made on every clock.

// File: rtl/tex_coord_cond.sv
module tex_coord_cond #(
  parameter int CW   = 16,
  parameter int FW   = 5,
  parameter int BW   = 12,
  parameter int BFW  = 2,
  parameter int OW   = 10,
  parameter int MAXM = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] coord_in,
  input  logic [3:0]    shift_code,
  input  logic [3:0]    mask,
  input  logic          mirror_en,
  input  logic          clamp_en,
  input  logic [BW-1:0] lo_bound,
  input  logic [BW-1:0] hi_bound,
  output logic          out_valid,
  output logic [OW-1:0] texel_out,
  output logic [FW-1:0] frac_out
);
  localparam int LSH = 5;
  localparam int SW  = CW + LSH;
  localparam int LOW = BW - BFW;
  localparam int PAD = SW - BW - (FW - BFW);

  logic signed [SW-1:0] ext, shifted;
  logic [3:0]           m_sat;

  assign ext   = {{LSH{coord_in[CW-1]}}, coord_in};
  assign m_sat = (mask > 4'(MAXM)) ? 4'(MAXM) : mask;

  always_comb begin
    if (shift_code == 4'd0)
      shifted = ext;
    else if (shift_code <= 4'd10)
      shifted = ext >>> shift_code;
    else
      shifted = ext <<< (5'd16 - {1'b0, shift_code});
  end

  logic                 s1_v, s1_mir, s1_clp;
  logic signed [SW-1:0] s1_c;
  logic [3:0]           s1_m;
  logic [BW-1:0]        s1_lo, s1_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_c   <= shifted;
    s1_m   <= m_sat;
    s1_mir <= mirror_en;
    s1_clp <= clamp_en;
    s1_lo  <= lo_bound;
    s1_hi  <= hi_bound;
  end

  logic signed [SW-1:0] lo_f, hi_f;
  logic                 do_clamp, below, above, flip;
  logic [OW+FW:0]       cl;
  logic [OW:0]          rel;
  logic [OW-1:0]        wmask, idx;

  assign lo_f     = $signed({{PAD{1'b0}}, s1_lo, {(FW-BFW){1'b0}}});
  assign hi_f     = $signed({{PAD{1'b0}}, s1_hi, {(FW-BFW){1'b0}}});
  assign do_clamp = (s1_m == 4'd0) || s1_clp;
  assign below    = do_clamp && (s1_c < lo_f);
  assign above    = do_clamp && (s1_c > hi_f);
  assign cl       = below ? lo_f[OW+FW:0] : above ? hi_f[OW+FW:0] : s1_c[OW+FW:0];
  assign rel      = cl[OW+FW:FW] - {{(OW+1-LOW){1'b0}}, s1_lo[BW-1:BFW]};
  assign wmask    = (OW'(1) << s1_m) - OW'(1);
  assign flip     = s1_mir && (s1_m != 4'd0) && rel[s1_m];
  assign idx      = (s1_m == 4'd0) ? rel[OW-1:0]
                  : flip ? (~rel[OW-1:0] & wmask) : (rel[OW-1:0] & wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_v;
  end

  always_ff @(posedge clk) begin
    texel_out <= idx;
    frac_out  <= cl[FW-1:0];
  end

  AST_S1_FOLLOWS:  assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> s1_v);   // R1
  AST_S1_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !s1_v); // R1
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) s1_v |=> out_valid);   // R1
  AST_OUT_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !s1_v |=> !out_valid); // R1
  AST_WRAP_RANGE:  assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s1_m != 4'd0 |=> {1'b0, texel_out} < ((OW+1)'(1) << $past(s1_m)));               // R5
  AST_CLAMP_SPAN:  assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s1_m == 4'd0 && s1_lo <= s1_hi |=>
      texel_out <= OW'($past(s1_hi[BW-1:BFW]) - $past(s1_lo[BW-1:BFW])));                    // R4
endmodule

// File: tb/tex_coord_cond_bench.sv
`timescale 1ns/1ps
module tex_coord_cond_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] coord_in = '0;
  logic [3:0]  shift_code = '0, mask = '0;
  logic        mirror_en = 1'b0, clamp_en = 1'b0;
  logic [11:0] lo_bound = '0, hi_bound = '0;
  logic        out_valid;
  logic [9:0]  texel_out;
  logic [4:0]  frac_out;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tex_coord_cond u_tex_coord_cond (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coord_in(coord_in),
    .shift_code(shift_code), .mask(mask), .mirror_en(mirror_en), .clamp_en(clamp_en),
    .lo_bound(lo_bound), .hi_bound(hi_bound),
    .out_valid(out_valid), .texel_out(texel_out), .frac_out(frac_out));

  typedef struct { bit v; int tex; int frac; string tag; } exp_t;
  exp_t p0, p1;

  function automatic void model(input logic [15:0] c16, input int sh, input int mk,
                                input bit mir, input bit clp, input int lo, input int hi,
                                output int tex, output int fr);
    int c, m, rel, lowb;
    c = int'($signed(c16));
    if (sh >= 1 && sh <= 10) c = c >>> sh;
    else if (sh >= 11) c = c <<< (16 - sh);
    m = (mk > 10) ? 10 : mk;
    if (m == 0 || clp) begin
      if (c < lo * 8) c = lo * 8;
      else if (c > hi * 8) c = hi * 8;
    end
    fr  = c & 31;
    rel = (c >>> 5) - (lo >> 2);
    if (m != 0) begin
      lowb = rel & ((1 << m) - 1);
      if (mir && ((rel >> m) & 1)) lowb = (~rel) & ((1 << m) - 1);
      rel = lowb;
    end
    tex = rel & 1023;
  endfunction

  task automatic compare();
    total++;
    if (out_valid !== p1.v) begin
      bad++;
      $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, p1.v);
    end else if (p1.v) begin
      total++;
      if (texel_out !== p1.tex[9:0] || frac_out !== p1.frac[4:0]) begin
        bad++;
        $display("FAIL %s texel actual=%0d expected=%0d frac actual=%0d expected=%0d",
                 p1.tag, texel_out, p1.tex, frac_out, p1.frac);
      end
    end
  endtask

  task automatic step(input bit v, input int c, input int sh, input int mk, input bit mir,
                      input bit clp, input int lo, input int hi, input string tag);
    int t, f;
    @(negedge clk);
    compare();
    in_valid = v; coord_in = 16'(c); shift_code = 4'(sh); mask = 4'(mk);
    mirror_en = mir; clamp_en = clp; lo_bound = 12'(lo); hi_bound = 12'(hi);
    model(16'(c), sh, mk, mir, clp, lo, hi, t, f);
    p1 = p0;
    p0.v = v; p0.tex = t; p0.frac = f; p0.tag = tag;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    p0.v = 0; p1.v = 0; p0.tag = "R1"; p1.tag = "R1";
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R10 out_valid actual=%0b expected=0", out_valid);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2: every shift code, positive and negative coordinates
    for (int s = 0; s < 16; s++) step(1, 1000 + 13, s, 10, 0, 0, 0, 4095, "R2");
    for (int s = 0; s < 16; s++) step(1, -777, s, 10, 0, 0, 0, 4095, "R2");
    // R3: fraction precision at the bounds
    step(1, 32 * 7 + 9, 0, 0, 0, 0, 28, 40, "R3");
    step(1, 32 * 7 + 9, 0, 0, 0, 0, 29, 40, "R3");
    step(1, 32 * 9 + 9, 0, 0, 0, 0, 4, 37, "R3");
    // R4: mask 0 limits even with clamp_en low
    step(1, 32 * 50, 0, 0, 0, 0, 8, 40, "R4");
    step(1, -32 * 5, 0, 0, 1, 0, 8, 40, "R4");
    // R5: wrap with clamp off and on
    for (int i = 0; i < 20; i++) step(1, 32 * i + 3, 0, 3, 0, 0, 0, 44, "R5");
    for (int i = 0; i < 20; i++) step(1, 32 * i, 0, 3, 0, 1, 0, 44, "R5");
    // R6: saturation of large masks
    for (int k = 10; k < 16; k++) step(1, 32 * 1500, 0, k, 0, 0, 0, 4095, "R6");
    step(1, 32 * 1500, 0, 15, 1, 0, 0, 4095, "R6");
    // R7: mirror on mask 2, and ignored on mask 0
    for (int i = 0; i < 8; i++) step(1, 32 * i, 0, 2, 1, 0, 0, 4095, "R7");
    step(1, 32 * 6, 0, 0, 1, 0, 0, 4095, "R7");
    // R8: limiting before folding
    for (int i = 0; i < 16; i++) step(1, 32 * i, 0, 2, 1, 1, 0, 11 * 4, "R8");
    // R9: relative index, below-low with and without limiting
    step(1, 32 * 2, 0, 4, 0, 0, 20, 200, "R9");
    step(1, 32 * 2, 0, 4, 0, 1, 20, 200, "R9");
    step(1, 32 * 30 + 17, 0, 0, 0, 0, 20, 200, "R9");
    step(1, -32 * 3, 0, 4, 1, 0, 20, 200, "R9");
    // R1: gaps in the strobe
    for (int i = 0; i < 12; i++) step(i % 3 == 0, 32 * i, 0, 4, 0, 0, 0, 4095, "R1");
    // Mixed random traffic
    for (int i = 0; i < 600; i++)
      step(($urandom % 5) != 0, int'($urandom % 65536) - 32768, $urandom % 16, $urandom % 16,
           $urandom % 2, $urandom % 2, $urandom % 4096, $urandom % 4096, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    finish_run();
  end
endmodule